// File: doc/BRIEF.md
# Handshaked Lamp Toggle Core

The block is a call-style core driven by a start/done/idle/ready handshake. Each call runs a long internal iteration count. At one fixed iteration it writes its one-bit result with the inverse of the bit it captured when the call was accepted, and it marks that write with a one-cycle valid strobe. A one-cycle completion pulse follows. The one-bit input carries its own valid qualifier.

A thin wrapper turns the core into a lamp blinker. The wrapper takes an active-low reset pin and inverts it into the core's synchronous active-high reset. For a short fixed delay after reset it keeps the call request and input qualifier low, then raises both for good. Each time the result strobe fires, the wrapper registers the result and feeds it back as the next call's input. With a 50 MHz clock and the default count of 100,000,000 iterations, the lamp changes state about every two seconds. The count is a parameter, so a small value can be used for simulation.

Top module: `lamp_toggle_top`

## Requirements
- R1: During and after a synchronous reset, the core drives idle 1, done 0, ready 0, out_vld 0 and out_bit 0.
- R2: A call is accepted at a clock edge where start is 1 and the core is idle or in its completion cycle. Idle is low from the cycle after acceptance until the core returns to idle.
- R3: out_vld is high for exactly one cycle per call, in the cycle that follows the edge TERMINAL_CNT-1 edges after the accepting edge. That edge ends iteration TERMINAL_CNT-2, and the strobe shows during the last iteration, TERMINAL_CNT-1.
- R4: The value on out_bit in the out_vld cycle is the inverse of the captured input bit. out_bit keeps that value until the next write.
- R5: The input bit is captured only at the accepting edge and only when in_vld is 1. With in_vld 0 the previously captured bit (0 after reset) is reused. Input changes at any other time have no effect.
- R6: done and ready are both high for exactly one cycle per call: the cycle right after the out_vld cycle.
- R7: If start is 1 in the completion cycle, the next call is accepted at once, so back-to-back calls repeat every TERMINAL_CNT+1 cycles. If start is 0 there, the core goes back to idle.
- R8: A start asserted while a call is running has no effect on the running call's timing or result.
- R9: The wrapper holds start and input-valid low until a DELAY_W-bit delay counter sets its top bit, then holds both high. With DELAY_W=2, the lamp first goes to 1 after edge TERMINAL_CNT+3, counting the first edge with rst_n_i high as edge 1. Before that the lamp is 0.
- R10: The wrapper registers each strobed result as the next input. The lamp then inverts every TERMINAL_CNT+1 cycles, giving 1,0,1,0,...

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_n_i | input | 1 | Active-low reset, sampled synchronously |
| lamp_o | output | 1 | Lamp drive, the core's registered result bit |

## Verification
The bench sets the wrapper to a terminal count of 100 and a second, stand-alone core to a terminal count of 8. Both keep the 32-bit counter. These small values put several complete calls within a few hundred cycles. The stand-alone core's handshake pins can then be driven directly: single calls, calls with the input qualifier low, a start raised mid-call, and a held start with the result fed back. The wrapper instance shows the post-reset launch delay and several lamp inversions at the exact cycles predicted.

// File: rtl/lamp_pkg.sv
package lamp_pkg;

    typedef enum logic [1:0] {
        CALL_IDLE = 2'd0,
        CALL_RUN  = 2'd1,
        CALL_FIN  = 2'd2
    } call_state_e;

    typedef struct packed {
        call_state_e state;
        logic        cap;
        logic        out;
        logic        vld;
    } call_regs_t;

    localparam call_regs_t CALL_RESET = '{
        state: CALL_IDLE,
        cap:   1'b0,
        out:   1'b0,
        vld:   1'b0
    };

endpackage

// File: rtl/lamp_iter_count.sv
module lamp_iter_count #(
    parameter int unsigned TERMINAL_CNT = 100_000_000,
    parameter int unsigned CNT_W        = 32
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic clear_i,
    input  logic adv_i,
    output logic fire_o,
    output logic last_o
);

    localparam logic [CNT_W-1:0] FIRE_AT = CNT_W'(TERMINAL_CNT - 2);
    localparam logic [CNT_W-1:0] LAST_AT = CNT_W'(TERMINAL_CNT - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (adv_i) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign fire_o = (cnt_q == FIRE_AT);
    assign last_o = (cnt_q == LAST_AT);

    // Iteration index never passes the final iteration
    assert_cnt_bound_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_q <= LAST_AT);

    // Controller never clears and advances at once
    assert_clear_adv_excl_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        !(clear_i && adv_i));

endmodule

// File: rtl/lamp_call_core.sv
module lamp_call_core
    import lamp_pkg::*;
#(
    parameter int unsigned TERMINAL_CNT = 100_000_000,
    parameter int unsigned CNT_W        = 32
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic start_i,
    output logic done_o,
    output logic idle_o,
    output logic ready_o,
    input  logic in_bit_i,
    input  logic in_vld_i,
    output logic out_bit_o,
    output logic out_vld_o
);

    call_regs_t r_d, r_q;
    logic       running;
    logic       accept;
    logic       fire;
    logic       last;

    assign running = (r_q.state == CALL_RUN);
    assign accept  = start_i && !running;

    lamp_iter_count #(
        .TERMINAL_CNT(TERMINAL_CNT),
        .CNT_W       (CNT_W)
    ) u_iter (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .clear_i(accept),
        .adv_i  (running && !last),
        .fire_o (fire),
        .last_o (last)
    );

    always_comb begin
        r_d     = r_q;
        r_d.vld = 1'b0;
        case (r_q.state)
            CALL_RUN: begin
                if (fire) begin
                    r_d.out = ~r_q.cap;
                    r_d.vld = 1'b1;
                end
                if (last) begin
                    r_d.state = CALL_FIN;
                end
            end
            default: begin
                if (start_i) begin
                    r_d.state = CALL_RUN;
                    if (in_vld_i) begin
                        r_d.cap = in_bit_i;
                    end
                end else begin
                    r_d.state = CALL_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            r_q <= CALL_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    assign idle_o    = (r_q.state == CALL_IDLE);
    assign done_o    = (r_q.state == CALL_FIN);
    assign ready_o   = (r_q.state == CALL_FIN);
    assign out_bit_o = r_q.out;
    assign out_vld_o = r_q.vld;

    // Leaving idle on an accepted call
    assert_idle_exit_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (idle_o && start_i) |=> !idle_o);

    // Strobe lasts one cycle
    assert_vld_one_cycle_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        out_vld_o |=> !out_vld_o);

    // Strobe shows only during the final iteration
    assert_vld_at_last_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        out_vld_o |-> (running && last));

    // Result bit moves only together with its strobe
    assert_out_on_vld_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(out_bit_o) |-> out_vld_o);

    // Captured input is frozen once a call runs
    assert_cap_hold_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        running |=> $stable(r_q.cap));

    // Completion follows the strobe directly
    assert_done_after_vld_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> $past(out_vld_o));

    // Held start chains into the next call
    assert_chain_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (done_o && start_i) |=> running);

    // Running call is not cut short or restarted
    assert_start_ignored_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (running && !last) |=> running);

endmodule

// File: rtl/lamp_launch.sv
module lamp_launch #(
    parameter int unsigned DELAY_W = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic go_o
);

    localparam int unsigned TOP = DELAY_W - 1;

    typedef struct packed {
        logic [DELAY_W-1:0] dly;
        logic               arm;
    } launch_regs_t;

    launch_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!r_q.dly[TOP]) begin
            r_d.dly = r_q.dly + DELAY_W'(1);
        end else begin
            r_d.arm = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign go_o = r_q.arm;

    // Once raised, the request stays up
    assert_go_sticky_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        go_o |=> go_o);

    // Request rises only after the delay top bit was set
    assert_go_after_delay_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(go_o) |-> $past(r_q.dly[TOP]));

endmodule

// File: rtl/lamp_toggle_top.sv
module lamp_toggle_top #(
    parameter int unsigned TERMINAL_CNT = 100_000_000,
    parameter int unsigned CNT_W        = 32,
    parameter int unsigned DELAY_W      = 2
) (
    input  logic clk_i,
    input  logic rst_n_i,
    output logic lamp_o
);

    logic rst;
    logic go;
    logic c_done, c_idle, c_ready;
    logic c_out, c_vld;
    logic fb_d, fb_q;

    assign rst = ~rst_n_i;

    lamp_launch #(
        .DELAY_W(DELAY_W)
    ) u_launch (
        .clk_i(clk_i),
        .rst_i(rst),
        .go_o (go)
    );

    lamp_call_core #(
        .TERMINAL_CNT(TERMINAL_CNT),
        .CNT_W       (CNT_W)
    ) u_core (
        .clk_i    (clk_i),
        .rst_i    (rst),
        .start_i  (go),
        .done_o   (c_done),
        .idle_o   (c_idle),
        .ready_o  (c_ready),
        .in_bit_i (fb_q),
        .in_vld_i (go),
        .out_bit_o(c_out),
        .out_vld_o(c_vld)
    );

    always_comb begin
        fb_d = fb_q;
        if (c_vld) begin
            fb_d = c_out;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst) begin
            fb_q <= 1'b0;
        end else begin
            fb_q <= fb_d;
        end
    end

    assign lamp_o = c_out;

    // Core stays idle while the launch delay runs
    assert_hold_off_R9: assert property (@(posedge clk_i) disable iff (rst)
        !go |-> c_idle);

    // Fed-back bit tracks each strobed result
    assert_fb_follow_R10: assert property (@(posedge clk_i) disable iff (rst)
        c_vld |=> (fb_q == $past(c_out)));

    // With the request held, completion chains into a new call
    assert_restart_R10: assert property (@(posedge clk_i) disable iff (rst)
        c_ready |=> !c_idle);

    // Completion pulse is a single cycle
    assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (rst)
        c_done |=> !c_done);

endmodule

// File: tb/lamp_toggle_top_test.sv
module lamp_toggle_top_test;

    localparam int T_CORE = 8;
    localparam int T_TOP  = 100;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    // wrapper under test
    logic rst_n;
    logic lamp;

    lamp_toggle_top #(.TERMINAL_CNT(T_TOP)) uut (
        .clk_i  (clk),
        .rst_n_i(rst_n),
        .lamp_o (lamp)
    );

    // stand-alone core for handshake checks
    logic c_rst, c_start, c_in_bit, c_in_vld;
    logic c_done, c_idle, c_ready, c_out, c_vld;

    lamp_call_core #(.TERMINAL_CNT(T_CORE)) core_uut (
        .clk_i    (clk),
        .rst_i    (c_rst),
        .start_i  (c_start),
        .done_o   (c_done),
        .idle_o   (c_idle),
        .ready_o  (c_ready),
        .in_bit_i (c_in_bit),
        .in_vld_i (c_in_vld),
        .out_bit_o(c_out),
        .out_vld_o(c_vld)
    );

    int n_chk  = 0;
    int n_fail = 0;

    // behavioural model: 0 idle, 1 running, 2 completing
    int   m_mode = 0;
    int   m_age  = 0;
    logic m_cap  = 1'b0;
    logic m_out  = 1'b0;
    logic m_vld  = 1'b0;

    task automatic check_bit(input string tag, input string what,
                             input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        if (c_rst) begin
            m_mode = 0; m_age = 0; m_cap = 1'b0; m_out = 1'b0; m_vld = 1'b0;
        end else begin
            m_vld = 1'b0;
            if (m_mode == 1) begin
                m_age++;
                if (m_age == T_CORE - 1) begin
                    m_out = ~m_cap;
                    m_vld = 1'b1;
                end
                if (m_age == T_CORE) m_mode = 2;
            end else if (c_start) begin
                m_mode = 1;
                m_age  = 0;
                if (c_in_vld) m_cap = c_in_bit;
            end else begin
                m_mode = 0;
            end
        end
    endtask

    // one clock: model steps at the edge, outputs compared at the falling edge
    task automatic core_cycle();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_bit("R2", "idle", c_idle, (m_mode == 0));
        check_bit("R6", "done", c_done, (m_mode == 2));
        check_bit("R6", "ready", c_ready, (m_mode == 2));
        check_bit("R3", "out_vld", c_vld, m_vld);
        check_bit("R4", "out_bit", c_out, m_out);
    endtask

    task automatic core_seq();
        int seq[$];
        int vld_at[$];
        c_rst = 1'b1; c_start = 1'b0; c_in_bit = 1'b0; c_in_vld = 1'b0;
        for (int i = 0; i < 3; i++) begin
            core_cycle();
            check_bit("R1", "reset idle", c_idle, 1'b1);
            check_bit("R1", "reset done", c_done, 1'b0);
            check_bit("R1", "reset vld", c_vld, 1'b0);
            check_bit("R1", "reset out", c_out, 1'b0);
        end
        c_rst = 1'b0;
        core_cycle();

        // single call capturing 0, with a stray start and input change mid-call (R8, R5)
        c_start = 1'b1; c_in_bit = 1'b0; c_in_vld = 1'b1;
        core_cycle();
        c_start = 1'b0;
        for (int k = 0; k < T_CORE + 4; k++) begin
            if (k == 2) c_start = 1'b1;
            if (k == 3) c_start = 1'b0;
            if (k == 4) c_in_bit = 1'b1;
            core_cycle();
        end
        check_bit("R4", "single call result", c_out, 1'b1);
        check_bit("R8", "idle after stray start", c_idle, 1'b1);

        // call with qualifier low: stale capture (0) reused, bit 1 ignored (R5)
        c_start = 1'b1; c_in_bit = 1'b1; c_in_vld = 1'b0;
        core_cycle();
        c_start = 1'b0;
        for (int k = 0; k < T_CORE + 3; k++) core_cycle();
        check_bit("R5", "unqualified input ignored", c_out, 1'b1);

        // chained calls with fed-back result from initial input 1 (R7, R4)
        c_start = 1'b1; c_in_bit = 1'b1; c_in_vld = 1'b1;
        for (int k = 0; k < 6 * (T_CORE + 1) && seq.size() < 4; k++) begin
            core_cycle();
            if (c_vld === 1'b1) begin
                seq.push_back(int'(c_out));
                vld_at.push_back(k);
                c_in_bit = c_out;
                if (seq.size() == 4) c_start = 1'b0;
            end
        end
        check_bit("R4", "chain length 4", (seq.size() == 4), 1'b1);
        if (seq.size() == 4) begin
            check_bit("R4", "chain call 1", seq[0][0], 1'b0);
            check_bit("R4", "chain call 2", seq[1][0], 1'b1);
            check_bit("R4", "chain call 3", seq[2][0], 1'b0);
            check_bit("R4", "chain call 4", seq[3][0], 1'b1);
            check_bit("R3", "first strobe position", (vld_at[0] == T_CORE - 1), 1'b1);
            for (int j = 1; j < 4; j++)
                check_bit("R7", "back-to-back spacing", (vld_at[j] - vld_at[j-1] == T_CORE + 1), 1'b1);
        end
        for (int k = 0; k < 3; k++) core_cycle();
        check_bit("R7", "idle after start dropped", c_idle, 1'b1);
    endtask

    task automatic top_seq();
        int first;
        int tg;
        first = T_TOP + 3;
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk);
            @(negedge clk);
            check_bit("R9", "lamp in reset", lamp, 1'b0);
        end
        rst_n = 1'b1;
        for (int n = 1; n <= first + 4 * (T_TOP + 1) + 5; n++) begin
            @(posedge clk);
            @(negedge clk);
            tg = (n >= first) ? ((n - first) / (T_TOP + 1) + 1) : 0;
            if (tg <= 1) check_bit("R9", "lamp launch timing", lamp, tg[0]);
            else         check_bit("R10", "lamp blink", lamp, tg[0]);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        fork
            core_seq();
            top_seq();
        join
        summary();
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R7 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

endmodule